// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous request port and an external 8K-word by 8-bit asynchronous static RAM. A client raises a request with a write flag, a 13-bit word address and, for stores, a data byte. The controller drives the memory's address lines, its two chip enables (one active low, one active high), its active-low write strobe and its active-low output enable. It also drives a bidirectional data bus, which is split into separate out, in and drive-enable signals.

Every phase of an access lasts a whole number of clock cycles. The controller computes these counts at elaboration from two parameters, the clock period and the memory speed grade. A phase that has to cover several nanosecond limits takes the largest of them. Between requests the memory is deselected and in standby. A load returns its byte on a one-cycle response pulse. A store writes its data during a write-strobe window, while the output enable is held high.

Top module: `sram_async_ctrl`

## Requirements
- R1: While idle, `req_ready` is 1, the memory is deselected (`mem_ce1_n`=1, `mem_ce2`=0), `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R2: A request with `req_write`=0 selects the memory with `mem_oe_n`=0 and `mem_we_n`=1. In the cycle `req_ready` returns to 1, `rsp_valid` is 1 for exactly one cycle and `rsp_rdata` carries the byte stored at the address.
- R3: A load keeps `mem_oe_n` low and `req_ready` low for RD cycles after acceptance. RD is the ceiling of max(cycle time, address access, output-enable access) divided by the clock period, with a minimum of one.
- R4: A store holds `mem_we_n` low for PUL consecutive cycles. PUL is the ceiling of max(strobe width, address-to-end, data-to-end) divided by the clock period.
- R5: `mem_oe_n` stays 1 whenever `mem_we_n` is 0 or `mem_dq_oe` is 1. The data drivers turn on only after the memory has been selected with `mem_oe_n` high for at least HZ cycles, where HZ is the ceiling of the output-disable time.
- R6: The data drivers stay on in the cycle in which `mem_we_n` rises, and they are off in the cycle after.
- R7: A store keeps `req_ready` low for max(HZ+PUL+1, ceiling of the write cycle time) cycles.
- R8: `mem_addr` and `mem_dq_out` do not change while the memory stays selected, or while the data drivers stay on.
- R9: `req_valid` is ignored while `req_ready` is 0. Such a request changes no memory content and does not lengthen the access in progress.
- R10: Each phase count is the ceiling of nanoseconds over the clock period, never below one. The timing sets are: grade 0 with cycle 45, access 45, OE access 25, disable 20, strobe 35, address setup 35, data setup 25 ns; grade 1 with 70, 70, 35, 25, 55, 60, 30 ns; grade 2 with 100, 100, 50, 25, 60, 80, 35 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Store data |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| rsp_valid | output | 1 | One-cycle load response strobe |
| rsp_rdata | output | 8 | Load data |
| mem_addr | output | 13 | Memory address lines |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_in | input | 8 | Data returned by memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The first directed stores and loads go to addresses 0 and 8191, because those expose any address-width or address-decode fault. A load of a location that was never written separates a real capture from stale data left in the capture register. A request raised while the controller is busy, followed by a load of that request's address, shows whether a busy request leaks into memory. Seeded random mixes of stores and loads, over a small address pool, follow stores with loads of the same address and with back-to-back loads and stores; these reveal ordering and contention faults. The bench measures every strobe and busy window in cycles and compares it with counts it derives itself.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_WSETUP,
    PH_WPULSE,
    PH_WEND,
    PH_WRECOV
  } phase_e;

  // Nanosecond limits for one speed grade
  typedef struct packed {
    int cyc_ns;   // minimum read / write cycle
    int acc_ns;   // address access
    int oea_ns;   // output-enable access
    int dis_ns;   // output disable after OE/WE deassert
    int pwe_ns;   // write strobe width
    int asu_ns;   // address setup to write end
    int dsu_ns;   // data setup to write end
  } timing_t;

  function automatic timing_t grade_timing(input int grade);
    timing_t t;
    case (grade)
      1:       t = '{cyc_ns: 70,  acc_ns: 70,  oea_ns: 35, dis_ns: 25,
                     pwe_ns: 55,  asu_ns: 60,  dsu_ns: 30};
      2:       t = '{cyc_ns: 100, acc_ns: 100, oea_ns: 50, dis_ns: 25,
                     pwe_ns: 60,  asu_ns: 80,  dsu_ns: 35};
      default: t = '{cyc_ns: 45,  acc_ns: 45,  oea_ns: 25, dis_ns: 20,
                     pwe_ns: 35,  asu_ns: 35,  dsu_ns: 25};
    endcase
    return t;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // ceiling of ns / period, at least one cycle
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val - 1'b1;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/sramc_fsm.sv
module sramc_fsm
  import sramc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int RD_C  = 5,
  parameter int SET_C = 2,
  parameter int PUL_C = 4,
  parameter int REC_C = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             last,
  output phase_e           phase,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             capture
);
  phase_e phase_q, phase_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = CNT_W'(1);
    case (phase_q)
      PH_IDLE: if (req_valid) begin
        load = 1'b1;
        if (req_write) begin
          phase_d  = PH_WSETUP;
          load_val = CNT_W'(SET_C);
        end else begin
          phase_d  = PH_READ;
          load_val = CNT_W'(RD_C);
        end
      end
      PH_READ:   if (last) phase_d = PH_IDLE;
      PH_WSETUP: if (last) begin
        phase_d  = PH_WPULSE;
        load     = 1'b1;
        load_val = CNT_W'(PUL_C);
      end
      PH_WPULSE: if (last) begin
        phase_d  = PH_WEND;
        load     = 1'b1;
        load_val = CNT_W'(1);
      end
      PH_WEND: if (last) begin
        if (REC_C > 0) begin
          phase_d  = PH_WRECOV;
          load     = 1'b1;
          load_val = CNT_W'(REC_C);
        end else begin
          phase_d  = PH_IDLE;
        end
      end
      PH_WRECOV: if (last) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  assign phase   = phase_q;
  assign accept  = (phase_q == PH_IDLE) && req_valid;
  assign capture = (phase_q == PH_READ) && last;
endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= mem_dq_in;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int SPEED_GRADE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);
  localparam timing_t TM = grade_timing(SPEED_GRADE);
  localparam int RD_C  = ns_to_cyc(max2(TM.cyc_ns, max2(TM.acc_ns, TM.oea_ns)), CLK_PERIOD_NS);
  localparam int HZ_C  = ns_to_cyc(TM.dis_ns, CLK_PERIOD_NS);
  localparam int PUL_C = ns_to_cyc(max2(TM.pwe_ns, max2(TM.asu_ns, TM.dsu_ns)), CLK_PERIOD_NS);
  localparam int WC_C  = ns_to_cyc(TM.cyc_ns, CLK_PERIOD_NS);
  localparam int WBASE = HZ_C + PUL_C + 1;
  localparam int REC_C = (WC_C > WBASE) ? (WC_C - WBASE) : 0;
  localparam int MAX_C = max2(max2(RD_C, HZ_C), max2(PUL_C, max2(REC_C, 1)));
  localparam int CNT_W = $clog2(MAX_C + 1);

  phase_e           phase;
  logic             t_load, t_last;
  logic [CNT_W-1:0] t_val;

  // named internal events
  logic ev_accept, ev_capture, ev_selected;

  sramc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .last(t_last)
  );

  sramc_fsm #(
    .CNT_W(CNT_W), .RD_C(RD_C), .SET_C(HZ_C), .PUL_C(PUL_C), .REC_C(REC_C)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .last(t_last), .phase(phase), .load(t_load), .load_val(t_val),
    .accept(ev_accept), .capture(ev_capture)
  );

  sramc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(ev_accept), .capture(ev_capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign ev_selected = (phase != PH_IDLE);
  assign req_ready   = (phase == PH_IDLE);
  assign mem_ce1_n   = !ev_selected;
  assign mem_ce2     = ev_selected;
  assign mem_oe_n    = (phase != PH_READ);
  assign mem_we_n    = (phase != PH_WPULSE);
  assign mem_dq_oe   = (phase == PH_WPULSE) || (phase == PH_WEND);
endmodule

// File: rtl/sramc_checker.sv
module sramc_checker #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int RD_C   = 5,
  parameter int HZ_C   = 2,
  parameter int PUL_C  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              ev_capture,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  logic [7:0] oe_lo_cnt, we_lo_cnt, hz_cnt;
  logic       sel;
  assign sel = !mem_ce1_n && mem_ce2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_lo_cnt <= '0;
      we_lo_cnt <= '0;
      hz_cnt    <= '0;
    end else begin
      oe_lo_cnt <= !mem_oe_n ? oe_lo_cnt + 8'd1 : 8'd0;
      we_lo_cnt <= !mem_we_n ? we_lo_cnt + 8'd1 : 8'd0;
      if (!sel)                               hz_cnt <= '0;
      else if (mem_oe_n && !mem_dq_oe && hz_cnt != 8'hFF) hz_cnt <= hz_cnt + 8'd1;
    end
  end

  p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe));

  p_read_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (sel && mem_we_n));

  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_after_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(ev_capture));

  p_read_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_lo_cnt == 8'(RD_C)));

  p_we_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt == 8'(PUL_C)));

  p_oe_high_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || mem_dq_oe) |-> mem_oe_n);

  p_drive_after_hz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (sel && hz_cnt >= 8'(HZ_C)));

  p_hold_at_we_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> !mem_dq_oe);

  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel)) |-> $stable(mem_addr));

  p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));
endmodule

bind sram_async_ctrl sramc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_C(RD_C), .HZ_C(HZ_C), .PUL_C(PUL_C)
) i_sramc_checker (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ev_capture(ev_capture), .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n),
  .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
module tb_sram_model (
  input  logic [12:0] a,
  input  logic        ce1_n,
  input  logic        ce2,
  input  logic        we_n,
  input  logic        oe_n,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  output logic        drive
);
  logic [7:0] mem [int];
  logic wact;
  assign wact = !ce1_n && ce2 && !we_n;

  always @(negedge wact) mem[int'(a)] = din;

  always @* begin
    drive = !ce1_n && ce2 && we_n && !oe_n;
    if (drive && mem.exists(int'(a))) dout = mem[int'(a)];
    else                              dout = 8'h00;
  end
endmodule

module test_sram_async_ctrl;
  localparam int CLK_NS = 10;
  localparam int GRADE  = 0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [12:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;
  logic        m_drive;

  int tests = 0, fails = 0;
  logic [7:0] shadow [int];

  always #(CLK_NS/2) clk = ~clk;

  sram_async_ctrl #(.CLK_PERIOD_NS(CLK_NS), .SPEED_GRADE(GRADE)) i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  tb_sram_model u_mem (
    .a(mem_addr), .ce1_n(mem_ce1_n), .ce2(mem_ce2), .we_n(mem_we_n),
    .oe_n(mem_oe_n), .din(mem_dq_out), .dout(mem_dq_in), .drive(m_drive)
  );

  // R10: cycle counts restated by counting up in whole periods
  function automatic int b_cycles(input int ns);
    int c = 0;
    while (c * CLK_NS < ns) c++;
    return (c == 0) ? 1 : c;
  endfunction
  function automatic int b_big(input int a, input int b, input int c);
    int m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  localparam int E_RD  = (GRADE == 0) ? 5 : 0; // placeholder unused for grade 0 table below
  int e_rd, e_hz, e_pul, e_wr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] shadow_rd(input logic [12:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
  endfunction

  // pin monitor
  logic        p_we_n = 1'b1, p_sel = 1'b0, p_oe = 1'b0, after_rise = 1'b0;
  logic [12:0] p_addr = '0;
  logic [7:0]  p_dq = '0;
  int we_lo = 0, hz_seen = 0;

  always @(negedge clk) if (rst_n) begin
    logic sel;
    sel = !mem_ce1_n && mem_ce2;
    if (req_ready)
      chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle pins",
          {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    if (!mem_oe_n) chk(sel && mem_we_n, "R2 read pins", {sel, mem_we_n}, 2'b11);
    if (!mem_we_n || mem_dq_oe) chk(mem_oe_n, "R5 oe high in write", mem_oe_n, 1);
    if (mem_dq_oe || m_drive) chk(!(mem_dq_oe && m_drive), "R5 bus contention", 1, 0);
    if (!mem_we_n) we_lo++;
    else if (we_lo > 0) begin
      chk(we_lo == e_pul, "R4 strobe length", we_lo, e_pul);
      we_lo = 0;
    end
    if (!p_we_n && mem_we_n) begin
      chk(mem_dq_oe, "R6 drive at strobe end", mem_dq_oe, 1);
      after_rise = 1'b1;
    end else if (after_rise) begin
      chk(!mem_dq_oe, "R6 release", mem_dq_oe, 0);
      after_rise = 1'b0;
    end
    if (!sel) hz_seen = 0;
    else if (mem_oe_n && !mem_dq_oe) hz_seen++;
    if (mem_dq_oe && !p_oe) chk(hz_seen >= e_hz, "R5 disable wait", hz_seen, e_hz);
    if (sel && p_sel) chk(mem_addr == p_addr, "R8 addr stable", mem_addr, p_addr);
    if (mem_dq_oe && p_oe) chk(mem_dq_out == p_dq, "R8 data stable", mem_dq_out, p_dq);
    p_we_n = mem_we_n; p_sel = sel; p_oe = mem_dq_oe; p_addr = mem_addr; p_dq = mem_dq_out;
  end

  task automatic do_op(input bit wr, input logic [12:0] a, input logic [7:0] d, input bit poke);
    int busy = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) begin
      busy++;
      if (poke && busy == 1) begin   // R9: request while busy
        req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 13'h1; req_wdata = ~d;
      end else begin
        req_valid = 1'b0;
      end
      if (!wr) chk(!rsp_valid, "R2 no early response", rsp_valid, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (wr) begin
      shadow[int'(a)] = d;
      chk(busy == e_wr, "R7 write busy length", busy, e_wr);
    end else begin
      chk(busy == e_rd, "R3 read busy length", busy, e_rd);
      chk(rsp_valid, "R2 response strobe", rsp_valid, 1);
      chk(rsp_rdata == shadow_rd(a), "R2 read data", rsp_rdata, shadow_rd(a));
      @(negedge clk);
      chk(!rsp_valid, "R2 one-cycle strobe", rsp_valid, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R10 grade-0 figures: cycle 45, access 45, oe 25, disable 20, strobe 35, asu 35, dsu 25
    e_rd  = b_cycles(b_big(45, 45, 25));
    e_hz  = b_cycles(20);
    e_pul = b_cycles(b_big(35, 35, 25));
    e_wr  = (e_hz + e_pul + 1 > b_cycles(45)) ? e_hz + e_pul + 1 : b_cycles(45);
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
        "R1 reset pins", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    do_op(1'b1, 13'd0,    8'hA5, 1'b0);
    do_op(1'b1, 13'd8191, 8'h5A, 1'b0);
    do_op(1'b0, 13'd0,    8'h00, 1'b0);
    do_op(1'b0, 13'd8191, 8'h00, 1'b0);
    do_op(1'b0, 13'd100,  8'h00, 1'b0);   // never written
    do_op(1'b1, 13'd200,  8'h3C, 1'b1);   // R9 poke at 201 during store
    do_op(1'b0, 13'd201,  8'h00, 1'b0);   // R9: 201 unchanged
    do_op(1'b0, 13'd300,  8'h00, 1'b1);   // R9 poke at 301 during load
    do_op(1'b0, 13'd301,  8'h00, 1'b0);
    do_op(1'b0, 13'd200,  8'h00, 1'b0);

    for (int i = 0; i < 60; i++) begin
      logic [12:0] a;
      a = 13'($urandom_range(0, 31) * 255);
      do_op(1'($urandom_range(0, 1)), a, 8'($urandom), 1'b0);
    end
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule